// File: doc/BRIEF.md
# Event Header and Parity Trailer Generator

This block wraps each event's payload in framing words. A start token, raised by a level-1 accept, opens the header phase. The block then sends a programmable number of header words, one per clock. Most header words are taken from a bank of static register slots. One selectable slot is replaced by a stamp built from a local tick/turn counter. When the last header word goes out, the block raises a header-done token, and the upstream stage begins sending payload.

During the payload phase the block sends nothing itself. It watches the payload word/valid stream and keeps a bitwise odd-parity register over every valid word. A payload-done token starts the trailer. The trailer opens with an identity word made of the data type and the tick number, continues with zero fill if the trailer is longer, and ends with the accumulated parity word. A trailer-done token marks the end of the event. All word counts are programmed as the count minus one.

The tick/turn counter is 24 bits wide: 8 bits of tick and 16 bits of turn. The tick advances once per accepted event, and the turn advances when the tick wraps. Each half can be zeroed by a software level or by a timing pulse that is gated by its own enable.

Top module: `evt_frame_gen`

## Requirements
- R1: A `start_i` seen while no event is in progress is accepted. The first header word appears with `out_valid_o` high two cycles after `start_i` is sampled. `hdr_last_i`+1 header words follow on consecutive cycles, each with `out_valid_o` high for exactly that cycle.
- R2: `hdr_done_o` goes high in the same cycle as the last header word. It stays high until the next accepted start, and both done tokens clear in the cycle after that start is accepted.
- R3: Header word k is the 16-bit slot `hdr_words_i[16k+15:16k]`. The exception is k equal to `tick_slot_i`: that word is the stamp {turn[7:0], tick[7:0]}, using the counter value held when the start was accepted.
- R4: Every accepted start advances the tick by one after the stamp is taken. A tick step from 255 to 0 advances the turn by one.
- R5: `tick_clr_i` zeroes the tick. `tick_sync_i` zeroes it only while `tick_sync_en_i` is high. `turn_clr_i`, `turn_sync_i` and `turn_sync_en_i` act the same way on the turn. A zeroing beats a same-cycle step.
- R6: `start_i` has no effect while an event is in progress (from acceptance until the last trailer word is sent). The tick is not stepped and no extra header is sent.
- R7: No word is emitted during the payload phase. `pay_done_i` ends that phase, and trailer word 0 appears two cycles after `pay_done_i` is sampled.
- R8: The trailer has `trl_last_i`+1 words. The last word is the parity word. Word 0 is {data_type_i[7:0], tick[7:0]} of the stamp, unless it is also the last word. Any words in between are 16'h0000.
- R9: The parity word is the bitwise XOR of two sets of words. The first set is every payload word with `pay_valid_i` high after the header phase, including a word sampled together with `pay_done_i`. The second set is every trailer word before the parity word. Parity is cleared at each accepted start.
- R10: `trl_done_o` goes high in the same cycle as the parity word and holds until the next accepted start. While it is high, `hdr_done_o` is also high.
- R11: Payload words with `pay_valid_i` high while idle or during the header phase are left out of the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Event start token |
| hdr_last_i | input | 3 | Header word count minus one |
| trl_last_i | input | 2 | Trailer word count minus one |
| tick_slot_i | input | 3 | Header index carrying the tick/turn stamp |
| data_type_i | input | 8 | Data type, repeated in the trailer |
| hdr_words_i | input | 128 | Eight 16-bit static header slots, slot k at bits 16k+15:16k |
| tick_clr_i | input | 1 | Software zeroing of tick |
| turn_clr_i | input | 1 | Software zeroing of turn |
| tick_sync_i | input | 1 | Timing pulse that zeroes tick when enabled |
| turn_sync_i | input | 1 | Timing pulse that zeroes turn when enabled |
| tick_sync_en_i | input | 1 | Enable for tick timing reset |
| turn_sync_en_i | input | 1 | Enable for turn timing reset |
| pay_valid_i | input | 1 | Payload word valid |
| pay_data_i | input | 16 | Payload word |
| pay_done_i | input | 1 | Payload-done token |
| hdr_done_o | output | 1 | Header-done token |
| trl_done_o | output | 1 | Trailer-done token |
| out_valid_o | output | 1 | Framing word valid |
| out_data_o | output | 16 | Framing word |

## Verification
Two events can land in the same cycle: the final payload word and the payload-done token. The bench drives the last valid word together with `pay_done_i` and checks that the parity word still includes it.

A second overlap is a start token arriving while an event is still running. The bench raises `start_i` during the payload phase and checks two things: the framing stream holds no extra header, and the next stamp shows the tick was not stepped.

// File: rtl/evt_frame_pkg.sv
package evt_frame_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_PAY  = 2'd2,
    PH_TRL  = 2'd3
  } phase_e;
endpackage

// File: rtl/evt_tick_turn.sv
module evt_tick_turn #(
  parameter int DW     = 16,
  parameter int TICK_W = 8,
  parameter int TURN_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          tick_clr_i,
  input  logic          turn_clr_i,
  input  logic          tick_sync_i,
  input  logic          turn_sync_i,
  input  logic          tick_sync_en_i,
  input  logic          turn_sync_en_i,
  output logic [DW-1:0] stamp_o
);
  localparam int STW = DW - TICK_W;

  logic [TICK_W-1:0] tick_q;
  logic [TURN_W-1:0] turn_q;
  logic              tick_zero, turn_zero, wrap;

  assign tick_zero = tick_clr_i | (tick_sync_i & tick_sync_en_i);
  assign turn_zero = turn_clr_i | (turn_sync_i & turn_sync_en_i);
  // turn advances only on a real tick rollover
  assign wrap      = step_i & (&tick_q) & ~tick_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      turn_q <= '0;
    end else begin
      if (tick_zero)   tick_q <= '0;
      else if (step_i) tick_q <= tick_q + 1'b1;
      if (turn_zero)   turn_q <= '0;
      else if (wrap)   turn_q <= turn_q + 1'b1;
    end
  end

  assign stamp_o = {turn_q[STW-1:0], tick_q};
endmodule

// File: rtl/evt_parity_acc.sv
module evt_parity_acc #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] par_o
);
  logic [DW-1:0] par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    par_q <= '0;
    else if (clr_i) par_q <= '0;
    else if (en_i)  par_q <= par_q ^ word_i;
  end

  assign par_o = par_q;
endmodule

// File: rtl/evt_frame_seq.sv
module evt_frame_seq
  import evt_frame_pkg::*;
#(
  parameter int DW        = 16,
  parameter int HDR_SLOTS = 8,
  parameter int TRL_SLOTS = 4,
  parameter int TICK_W    = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [$clog2(HDR_SLOTS)-1:0] hdr_last_i,
  input  logic [$clog2(TRL_SLOTS)-1:0] trl_last_i,
  input  logic [$clog2(HDR_SLOTS)-1:0] tick_slot_i,
  input  logic [DW-TICK_W-1:0]    data_type_i,
  input  logic [HDR_SLOTS*DW-1:0] hdr_words_i,
  input  logic [DW-1:0]           stamp_i,
  input  logic [DW-1:0]           par_i,
  input  logic                    pay_valid_i,
  input  logic [DW-1:0]           pay_data_i,
  input  logic                    pay_done_i,
  output logic                    step_o,
  output logic                    acc_clr_o,
  output logic                    acc_en_o,
  output logic [DW-1:0]           acc_word_o,
  output logic                    hdr_done_o,
  output logic                    trl_done_o,
  output logic                    out_valid_o,
  output logic [DW-1:0]           out_data_o
);
  localparam int HCW = $clog2(HDR_SLOTS);
  localparam int TCW = $clog2(TRL_SLOTS);
  localparam int IW  = (HCW > TCW) ? HCW : TCW;

  phase_e          phase_q;
  logic [IW-1:0]   idx_q;
  logic [HCW-1:0]  hl_q, slot_q;
  logic [TCW-1:0]  tl_q;
  logic [DW-1:0]   stamp_q;
  logic            hdr_done_q, trl_done_q, out_valid_q;
  logic [DW-1:0]   out_data_q;

  logic [DW-1:0]   slot_w [HDR_SLOTS];
  logic [DW-1:0]   hdr_word, trl_word, id_word;
  logic            accept, hdr_last, trl_last;

  for (genvar g = 0; g < HDR_SLOTS; g++) begin : g_slot
    assign slot_w[g] = hdr_words_i[g*DW +: DW];
  end

  assign accept   = (phase_q == PH_IDLE) & start_i;
  assign hdr_last = (idx_q == IW'(hl_q));
  assign trl_last = (idx_q == IW'(tl_q));
  assign id_word  = {data_type_i, stamp_q[TICK_W-1:0]};
  assign hdr_word = (idx_q[HCW-1:0] == slot_q) ? stamp_q : slot_w[idx_q[HCW-1:0]];

  always_comb begin
    if (trl_last)          trl_word = par_i;
    else if (idx_q == '0)  trl_word = id_word;
    else                   trl_word = '0;
  end

  // parity sees payload words and every trailer word ahead of the parity word
  assign acc_clr_o  = accept;
  assign acc_en_o   = ((phase_q == PH_PAY) & pay_valid_i) | ((phase_q == PH_TRL) & ~trl_last);
  assign acc_word_o = (phase_q == PH_PAY) ? pay_data_i : trl_word;
  assign step_o     = accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      idx_q       <= '0;
      hl_q        <= '0;
      tl_q        <= '0;
      slot_q      <= '0;
      stamp_q     <= '0;
      hdr_done_q  <= 1'b0;
      trl_done_q  <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q    <= PH_HDR;
            idx_q      <= '0;
            hl_q       <= hdr_last_i;
            tl_q       <= trl_last_i;
            slot_q     <= tick_slot_i;
            stamp_q    <= stamp_i;
            hdr_done_q <= 1'b0;
            trl_done_q <= 1'b0;
          end
        end
        PH_HDR: begin
          out_valid_q <= 1'b1;
          out_data_q  <= hdr_word;
          if (hdr_last) begin
            phase_q    <= PH_PAY;
            hdr_done_q <= 1'b1;
            idx_q      <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        PH_PAY: begin
          if (pay_done_i) begin
            phase_q <= PH_TRL;
            idx_q   <= '0;
          end
        end
        PH_TRL: begin
          out_valid_q <= 1'b1;
          out_data_q  <= trl_word;
          if (trl_last) begin
            phase_q    <= PH_IDLE;
            trl_done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign hdr_done_o  = hdr_done_q;
  assign trl_done_o  = trl_done_q;
  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
endmodule

// File: rtl/evt_frame_gen.sv
module evt_frame_gen #(
  parameter int DW        = 16,
  parameter int HDR_SLOTS = 8,
  parameter int TRL_SLOTS = 4,
  parameter int TICK_W    = 8,
  parameter int TURN_W    = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [$clog2(HDR_SLOTS)-1:0] hdr_last_i,
  input  logic [$clog2(TRL_SLOTS)-1:0] trl_last_i,
  input  logic [$clog2(HDR_SLOTS)-1:0] tick_slot_i,
  input  logic [DW-TICK_W-1:0]         data_type_i,
  input  logic [HDR_SLOTS*DW-1:0]      hdr_words_i,
  input  logic                         tick_clr_i,
  input  logic                         turn_clr_i,
  input  logic                         tick_sync_i,
  input  logic                         turn_sync_i,
  input  logic                         tick_sync_en_i,
  input  logic                         turn_sync_en_i,
  input  logic                         pay_valid_i,
  input  logic [DW-1:0]                pay_data_i,
  input  logic                         pay_done_i,
  output logic                         hdr_done_o,
  output logic                         trl_done_o,
  output logic                         out_valid_o,
  output logic [DW-1:0]                out_data_o
);
  logic          step;
  logic          acc_clr, acc_en;
  logic [DW-1:0] acc_word, par, stamp;

  evt_tick_turn #(.DW(DW), .TICK_W(TICK_W), .TURN_W(TURN_W)) u_tt (
    .clk_i, .rst_ni,
    .step_i        (step),
    .tick_clr_i, .turn_clr_i,
    .tick_sync_i, .turn_sync_i,
    .tick_sync_en_i, .turn_sync_en_i,
    .stamp_o       (stamp)
  );

  evt_parity_acc #(.DW(DW)) u_par (
    .clk_i, .rst_ni,
    .clr_i  (acc_clr),
    .en_i   (acc_en),
    .word_i (acc_word),
    .par_o  (par)
  );

  evt_frame_seq #(
    .DW(DW), .HDR_SLOTS(HDR_SLOTS), .TRL_SLOTS(TRL_SLOTS), .TICK_W(TICK_W)
  ) u_seq (
    .clk_i, .rst_ni,
    .start_i, .hdr_last_i, .trl_last_i, .tick_slot_i,
    .data_type_i, .hdr_words_i,
    .stamp_i     (stamp),
    .par_i       (par),
    .pay_valid_i, .pay_data_i, .pay_done_i,
    .step_o      (step),
    .acc_clr_o   (acc_clr),
    .acc_en_o    (acc_en),
    .acc_word_o  (acc_word),
    .hdr_done_o, .trl_done_o, .out_valid_o, .out_data_o
  );
endmodule

// File: rtl/evt_frame_chk.sv
module evt_frame_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic hdr_done_o,
  input logic trl_done_o,
  input logic out_valid_o
);
  p_hdr_done_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hdr_done_o) |-> out_valid_o);

  p_done_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trl_done_o && start_i) |=> (!hdr_done_o && !trl_done_o));

  p_start_header_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trl_done_o && start_i) |=> ##1 out_valid_o);

  p_busy_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_done_o && !trl_done_o && start_i) |=> hdr_done_o);

  p_trl_done_word_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trl_done_o) |-> out_valid_o);

  p_done_order_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trl_done_o |-> hdr_done_o);
endmodule

bind evt_frame_gen evt_frame_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .hdr_done_o  (hdr_done_o),
  .trl_done_o  (trl_done_o),
  .out_valid_o (out_valid_o)
);

// File: tb/evt_frame_gen_tb.sv
module evt_frame_gen_tb_top;
  localparam int CLK_P = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         start_i;
  logic [2:0]   hdr_last_i, tick_slot_i;
  logic [1:0]   trl_last_i;
  logic [7:0]   data_type_i;
  logic [127:0] hdr_words_i;
  logic         tick_clr_i, turn_clr_i, tick_sync_i, turn_sync_i;
  logic         tick_sync_en_i, turn_sync_en_i;
  logic         pay_valid_i, pay_done_i;
  logic [15:0]  pay_data_i;
  logic         hdr_done_o, trl_done_o, out_valid_o;
  logic [15:0]  out_data_o;

  int vec = 0;
  int miss = 0;
  int m_tick = 0;
  int m_turn = 0;
  logic [15:0] m_par;
  logic [15:0] m_stamp;

  always #(CLK_P/2) clk_i = ~clk_i;

  evt_frame_gen dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] slot_val(int k);
    return 16'hA000 + 16'(k) * 16'h0111;
  endfunction

  // one full event, checked every clock
  task automatic run_evt(int hl, int tl, int slot, int npay, bit gap,
                         bit early_pay, bit busy_start);
    logic [15:0] w;
    hdr_last_i  = 3'(hl);
    trl_last_i  = 2'(tl);
    tick_slot_i = 3'(slot);
    start_i     = 1'b1;
    if (early_pay) begin pay_valid_i = 1'b1; pay_data_i = 16'hFFFF; end
    m_stamp = {8'(m_turn), 8'(m_tick)};
    m_par   = '0;
    m_tick  = (m_tick + 1) % 256;
    if (m_tick == 0) m_turn = (m_turn + 1) % 65536;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R1 no word on accept cycle", {31'd0, out_valid_o}, 32'd0);
    for (int k = 0; k <= hl; k++) begin
      @(negedge clk_i);
      w = (k == slot) ? m_stamp : slot_val(k);
      check("R1 header valid", {31'd0, out_valid_o}, 32'd1);
      check("R3 header word", {16'd0, out_data_o}, {16'd0, w});
      check("R2 hdr_done timing", {31'd0, hdr_done_o}, {31'd0, (k == hl)});
    end
    pay_valid_i = 1'b0;
    for (int p = 0; p < npay; p++) begin
      if (gap && p[0]) begin
        pay_valid_i = 1'b0;
        @(negedge clk_i);
        check("R7 quiet in payload", {31'd0, out_valid_o}, 32'd0);
      end
      pay_valid_i = 1'b1;
      pay_data_i  = 16'(16'h1357 * (p + 3)) ^ 16'(hl << 9);
      pay_done_i  = (p == npay - 1);
      if (busy_start && p == 0) start_i = 1'b1;
      m_par ^= pay_data_i;
      @(negedge clk_i);
      start_i = 1'b0;
      check("R7 quiet in payload", {31'd0, out_valid_o}, 32'd0);
    end
    if (npay == 0) begin
      pay_done_i = 1'b1;
      @(negedge clk_i);
    end
    pay_valid_i = 1'b0;
    pay_done_i  = 1'b0;
    if (busy_start) start_i = 1'b1;
    check("R7 trailer not yet", {31'd0, out_valid_o}, 32'd0);
    for (int j = 0; j <= tl; j++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (j == tl)     w = m_par;
      else if (j == 0) w = {data_type_i, m_stamp[7:0]};
      else             w = 16'h0000;
      check("R8 trailer valid", {31'd0, out_valid_o}, 32'd1);
      if (j == tl) check("R9 parity word", {16'd0, out_data_o}, {16'd0, w});
      else         check("R8 trailer word", {16'd0, out_data_o}, {16'd0, w});
      check("R10 trl_done timing", {31'd0, trl_done_o}, {31'd0, (j == tl)});
      if (j != tl) m_par ^= w;
    end
    @(negedge clk_i);
    check("R6 no extra word after event", {31'd0, out_valid_o}, 32'd0);
    check("R10 trl_done holds", {30'd0, hdr_done_o, trl_done_o}, 32'd3);
  endtask

  initial begin
    #(CLK_P * 150000);
    miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; start_i = 0; pay_valid_i = 0; pay_done_i = 0; pay_data_i = 0;
    tick_clr_i = 0; turn_clr_i = 0; tick_sync_i = 0; turn_sync_i = 0;
    tick_sync_en_i = 0; turn_sync_en_i = 0;
    hdr_last_i = 0; trl_last_i = 0; tick_slot_i = 0; data_type_i = 8'h5C;
    for (int k = 0; k < 8; k++) hdr_words_i[k*16 +: 16] = slot_val(k);
    repeat (3) @(negedge clk_i);
    check("R1 reset state", {29'd0, out_valid_o, hdr_done_o, trl_done_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R3 R8 R9: basic event, stamp at slot 2, collision of last word with done
    run_evt(5, 3, 2, 6, 0, 0, 0);
    // R11: payload valid during header is excluded; gaps in payload
    data_type_i = 8'h3A;
    run_evt(7, 2, 7, 5, 1, 1, 0);
    // R8: single-word trailer is parity only; stamp slot beyond header length
    run_evt(0, 0, 4, 1, 0, 0, 0);
    // R8: two-word trailer, no payload words
    run_evt(1, 1, 0, 0, 0, 0, 0);
    // R6: start during payload and on trailer entry ignored
    run_evt(2, 2, 1, 3, 0, 0, 1);
    run_evt(2, 1, 0, 2, 0, 0, 0);

    // R5: sync pulses without enable do nothing
    tick_sync_i = 1; turn_sync_i = 1;
    @(negedge clk_i);
    tick_sync_i = 0; turn_sync_i = 0;
    run_evt(0, 1, 0, 1, 0, 0, 0);
    // R5: software tick clear
    tick_clr_i = 1;
    @(negedge clk_i);
    tick_clr_i = 0;
    m_tick = 0;
    run_evt(0, 1, 0, 2, 0, 0, 0);
    // R5: enabled tick sync
    tick_sync_en_i = 1; tick_sync_i = 1;
    @(negedge clk_i);
    tick_sync_i = 0; tick_sync_en_i = 0;
    m_tick = 0;
    run_evt(1, 1, 1, 1, 0, 0, 0);

    // R4: drive the tick through a wrap so the turn steps
    while (m_tick != 255) run_evt(0, 0, 0, 0, 0, 0, 0);
    run_evt(0, 0, 0, 0, 0, 0, 0);
    run_evt(0, 1, 0, 1, 0, 0, 0);
    check("R4 turn stepped on wrap", m_turn, 32'd1);

    // R5: enabled turn sync zeroes turn
    turn_sync_en_i = 1; turn_sync_i = 1;
    @(negedge clk_i);
    turn_sync_i = 0; turn_sync_en_i = 0;
    m_turn = 0;
    run_evt(3, 1, 3, 2, 0, 0, 0);
    // R5: software turn clear (turn already zero, tick unaffected)
    turn_clr_i = 1;
    @(negedge clk_i);
    turn_clr_i = 0;
    run_evt(3, 3, 0, 4, 1, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule